// File: doc/BRIEF.md
# Function-Unit to Register Dependency Matrix

This block keeps a bit matrix with one row for each function unit (FU) and one column for each architectural register. The row index is the FU's identity, so no tag is stored anywhere in the block. Registers arrive in one-hot form. Recording that an instruction uses a register therefore sets a single bit; no binary field is written. When an instruction is issued to a free FU, the block records two things in that FU's row: the register the instruction will produce (its write bits) and the registers it must still read (its read bits).

For each register, the block ORs the matching column across every row and inverts the result. This gives two "free" vectors, one for reads and one for writes. A scoreboard reads these vectors to see whether any FU still has a pending read of a register, or a pending result for it. The raw row contents and a per-FU busy flag are also brought out, so that a companion FU-to-FU matrix can build its dependencies from them. An FU drops its read bits once it has latched its operands, and drops its write bits once its result has been written back.

Top module: `fu_reg_dep_matrix`

## Requirements
- R1: While rst_n is low at a rising clock edge, every row is cleared. Afterwards all read and write bits are 0, both free vectors are all ones, fu_busy is 0, and issue_stall is 0 while issue_valid is 0.
- R2: An accepted issue to FU f loads issue_dest into f's write bits, visible after the next rising edge. Bit r of a row slice (bits f*NUM_REG+r of the flat row vector) stands for register r.
- R3: An accepted issue sets f's read bits to the OR of all NUM_SRC source one-hots (source s occupies bits s*NUM_REG and up of issue_src). Two sources that name the same register set one bit.
- R4: reg_rd_free[r] is 1 exactly when no row has read bit r set. reg_wr_free[r] is 1 exactly when no row has write bit r set.
- R5: rd_done[f] high at a rising edge clears f's read bits and leaves its write bits unchanged.
- R6: wr_done[f] high at a rising edge clears f's write bits and leaves its read bits unchanged.
- R7: fu_busy[f] is 1 when row f holds any set bit. An issue whose target is busy raises issue_stall in the same cycle, and the matrix changes only through the done strobes.
- R8: An issue whose issue_fu is not exactly one-hot (zero bits or several bits set) raises issue_stall and writes nothing.
- R9: An issue that names no registers at all is accepted (issue_stall 0) and leaves its row empty and not busy.
- R10: If an accepted issue and rd_done/wr_done for the same idle FU arrive in the same cycle, the newly issued bits are kept. The strobes act only on the row's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | Issue request this cycle |
| issue_fu | input | NUM_FU | One-hot target FU |
| issue_dest | input | NUM_REG | One-hot destination register (zero for none) |
| issue_src | input | NUM_SRC*NUM_REG | Concatenated one-hot source registers |
| rd_done | input | NUM_FU | Per-FU operands-read strobe |
| wr_done | input | NUM_FU | Per-FU result-written strobe |
| issue_stall | output | 1 | Issue rejected this cycle |
| fu_busy | output | NUM_FU | Row holds any pending bit |
| fu_rd_row | output | NUM_FU*NUM_REG | Read bits of all rows, row f at f*NUM_REG |
| fu_wr_row | output | NUM_FU*NUM_REG | Write bits of all rows, row f at f*NUM_REG |
| reg_rd_free | output | NUM_REG | No FU has a pending read of register r |
| reg_wr_free | output | NUM_REG | No FU has a pending write of register r |

## Verification
The bench aims at a few specific corner cases:
- A done strobe that coincides with an issue to the same idle FU. A design that applies the clear after the load would lose the new instruction's dependencies.
- Target vectors with zero bits or two bits set. A design that decodes the lowest bit would write a row it was never asked to write.
- Sources that repeat a register, and issues with no registers. These catch a merge that counts instead of ORs, and a busy flag that is set by issue rather than by content.
- Random traffic that keeps several FUs busy while strobes retire them. This exposes a stall that ignores the target row, and free vectors that miss a column.

// File: rtl/fu_reg_pkg.sv
// Package: default sizes shared by the matrix, its checker and its bench.
// Assumes: nothing; holds constants only.
package fu_reg_pkg;
    localparam int unsigned FRM_DEF_FU  = 4;
    localparam int unsigned FRM_DEF_REG = 8;
    localparam int unsigned FRM_DEF_SRC = 2;
endpackage

// File: rtl/frm_issue_ctrl.sv
// Module: issue acceptance. Decides whether the request may load a row and
// merges the source one-hots into one read mask.
// Assumes: row_busy reflects the registered row contents of this cycle.
module frm_issue_ctrl #(
    parameter int unsigned NUM_FU  = fu_reg_pkg::FRM_DEF_FU,
    parameter int unsigned NUM_REG = fu_reg_pkg::FRM_DEF_REG,
    parameter int unsigned NUM_SRC = fu_reg_pkg::FRM_DEF_SRC
) (
    input  logic                       issue_valid,
    input  logic [NUM_FU-1:0]          issue_fu,
    input  logic [NUM_FU-1:0]          row_busy,
    input  logic [NUM_SRC*NUM_REG-1:0] issue_src,
    output logic [NUM_FU-1:0]          load_vec,
    output logic                       issue_stall,
    output logic [NUM_REG-1:0]         src_merged
);
    logic target_ok;
    logic target_hit;

    // Reject a malformed target or a target row that is still occupied.
    always_comb begin
        target_ok   = $onehot(issue_fu);
        target_hit  = |(issue_fu & row_busy);
        issue_stall = issue_valid & (~target_ok | target_hit);
        load_vec    = (issue_valid & ~issue_stall) ? issue_fu : '0;
    end

    // OR all source one-hots together; a repeated register collapses to one bit.
    always_comb begin
        src_merged = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            src_merged = src_merged | issue_src[s*NUM_REG +: NUM_REG];
        end
    end
endmodule

// File: rtl/frm_dep_row.sv
// Module: one FU row of the matrix, holding its read bits and write bits.
// Assumes: load is asserted only while the row is empty (enforced upstream).
module frm_dep_row #(
    parameter int unsigned NUM_REG = fu_reg_pkg::FRM_DEF_REG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [NUM_REG-1:0] dest,
    input  logic [NUM_REG-1:0] src,
    input  logic               rd_clr,
    input  logic               wr_clr,
    output logic [NUM_REG-1:0] rd_bits,
    output logic [NUM_REG-1:0] wr_bits,
    output logic               busy
);
    logic [NUM_REG-1:0] rd_q;
    logic [NUM_REG-1:0] wr_q;

    // Clears act on the old contents; a fresh load is ORed in after them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            wr_q <= '0;
        end else begin
            rd_q <= (rd_clr ? '0 : rd_q) | (load ? src  : '0);
            wr_q <= (wr_clr ? '0 : wr_q) | (load ? dest : '0);
        end
    end

    // Expose row state; the row is busy while any bit is pending.
    always_comb begin
        rd_bits = rd_q;
        wr_bits = wr_q;
        busy    = |{rd_q, wr_q};
    end
endmodule

// File: rtl/frm_col_nor.sv
// Module: per-register NOR across all FU rows of one bit plane.
// Assumes: rows is packed row-major, row f at bits f*NUM_REG.
module frm_col_nor #(
    parameter int unsigned NUM_FU  = fu_reg_pkg::FRM_DEF_FU,
    parameter int unsigned NUM_REG = fu_reg_pkg::FRM_DEF_REG
) (
    input  logic [NUM_FU*NUM_REG-1:0] rows,
    output logic [NUM_REG-1:0]        free
);
    for (genvar r = 0; r < NUM_REG; r++) begin : g_col
        logic any_set;
        // Collect column r from every row and invert.
        always_comb begin
            any_set = 1'b0;
            for (int f = 0; f < NUM_FU; f++) begin
                any_set = any_set | rows[f*NUM_REG + r];
            end
            free[r] = ~any_set;
        end
    end
endmodule

// File: rtl/fu_reg_dep_matrix.sv
// Module: FU-to-register dependency matrix top. One row per FU, one column
// per register, separate read and write planes, NOR-derived free vectors.
// Assumes: register and FU identities arrive one-hot; synchronous active-low reset.
module fu_reg_dep_matrix #(
    parameter int unsigned NUM_FU  = fu_reg_pkg::FRM_DEF_FU,
    parameter int unsigned NUM_REG = fu_reg_pkg::FRM_DEF_REG,
    parameter int unsigned NUM_SRC = fu_reg_pkg::FRM_DEF_SRC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       issue_valid,
    input  logic [NUM_FU-1:0]          issue_fu,
    input  logic [NUM_REG-1:0]         issue_dest,
    input  logic [NUM_SRC*NUM_REG-1:0] issue_src,
    input  logic [NUM_FU-1:0]          rd_done,
    input  logic [NUM_FU-1:0]          wr_done,
    output logic                       issue_stall,
    output logic [NUM_FU-1:0]          fu_busy,
    output logic [NUM_FU*NUM_REG-1:0]  fu_rd_row,
    output logic [NUM_FU*NUM_REG-1:0]  fu_wr_row,
    output logic [NUM_REG-1:0]         reg_rd_free,
    output logic [NUM_REG-1:0]         reg_wr_free
);
    localparam int unsigned PLANE_W = NUM_FU * NUM_REG;

    logic [NUM_FU-1:0]  load_vec;
    logic [NUM_REG-1:0] src_merged;
    logic [PLANE_W-1:0] rd_plane;
    logic [PLANE_W-1:0] wr_plane;
    logic [NUM_FU-1:0]  busy_vec;

    frm_issue_ctrl #(
        .NUM_FU (NUM_FU),
        .NUM_REG(NUM_REG),
        .NUM_SRC(NUM_SRC)
    ) u_issue (
        .issue_valid(issue_valid),
        .issue_fu   (issue_fu),
        .row_busy   (busy_vec),
        .issue_src  (issue_src),
        .load_vec   (load_vec),
        .issue_stall(issue_stall),
        .src_merged (src_merged)
    );

    for (genvar f = 0; f < NUM_FU; f++) begin : g_row
        frm_dep_row #(
            .NUM_REG(NUM_REG)
        ) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load_vec[f]),
            .dest   (issue_dest),
            .src    (src_merged),
            .rd_clr (rd_done[f]),
            .wr_clr (wr_done[f]),
            .rd_bits(rd_plane[f*NUM_REG +: NUM_REG]),
            .wr_bits(wr_plane[f*NUM_REG +: NUM_REG]),
            .busy   (busy_vec[f])
        );
    end

    frm_col_nor #(
        .NUM_FU (NUM_FU),
        .NUM_REG(NUM_REG)
    ) u_rd_nor (
        .rows(rd_plane),
        .free(reg_rd_free)
    );

    frm_col_nor #(
        .NUM_FU (NUM_FU),
        .NUM_REG(NUM_REG)
    ) u_wr_nor (
        .rows(wr_plane),
        .free(reg_wr_free)
    );

    // Drive the row-data outputs for the neighbouring FU-to-FU matrix.
    always_comb begin
        fu_rd_row = rd_plane;
        fu_wr_row = wr_plane;
        fu_busy   = busy_vec;
    end
endmodule

// File: rtl/frm_checker.sv
// Module: property checker for the dependency matrix, bound to every instance.
// Assumes: observes ports only.
module frm_checker #(
    parameter int unsigned NUM_FU  = fu_reg_pkg::FRM_DEF_FU,
    parameter int unsigned NUM_REG = fu_reg_pkg::FRM_DEF_REG,
    parameter int unsigned NUM_SRC = fu_reg_pkg::FRM_DEF_SRC
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       issue_valid,
    input logic [NUM_FU-1:0]          issue_fu,
    input logic [NUM_REG-1:0]         issue_dest,
    input logic [NUM_SRC*NUM_REG-1:0] issue_src,
    input logic [NUM_FU-1:0]          rd_done,
    input logic [NUM_FU-1:0]          wr_done,
    input logic                       issue_stall,
    input logic [NUM_FU*NUM_REG-1:0]  fu_rd_row,
    input logic [NUM_FU*NUM_REG-1:0]  fu_wr_row,
    input logic [NUM_REG-1:0]         reg_rd_free,
    input logic [NUM_REG-1:0]         reg_wr_free
);
    logic               accepted;
    logic [NUM_REG-1:0] chk_src;
    logic [NUM_REG-1:0] rd_col_any;
    logic [NUM_REG-1:0] wr_col_any;

    // Independent view of acceptance, merged sources and column occupancy.
    always_comb begin
        accepted   = issue_valid & ~issue_stall;
        chk_src    = '0;
        rd_col_any = '0;
        wr_col_any = '0;
        for (int s = 0; s < NUM_SRC; s++) chk_src = chk_src | issue_src[s*NUM_REG +: NUM_REG];
        for (int f = 0; f < NUM_FU; f++) begin
            rd_col_any = rd_col_any | fu_rd_row[f*NUM_REG +: NUM_REG];
            wr_col_any = wr_col_any | fu_wr_row[f*NUM_REG +: NUM_REG];
        end
    end

    AST_FREE_NOR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_free == ~rd_col_any) && (reg_wr_free == ~wr_col_any)); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stall && (rd_done == '0) && (wr_done == '0) |=> $stable(fu_rd_row) && $stable(fu_wr_row)); // R7

    AST_BAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !$onehot(issue_fu) |-> issue_stall); // R8

    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
        AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            accepted && issue_fu[f] |=> fu_wr_row[f*NUM_REG +: NUM_REG] == $past(issue_dest)); // R2
        AST_RD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            accepted && issue_fu[f] |=> fu_rd_row[f*NUM_REG +: NUM_REG] == $past(chk_src)); // R3
        AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            rd_done[f] && !(accepted && issue_fu[f]) && !wr_done[f]
            |=> (fu_rd_row[f*NUM_REG +: NUM_REG] == '0)
                && $stable(fu_wr_row[f*NUM_REG +: NUM_REG])); // R5
        AST_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            wr_done[f] && !(accepted && issue_fu[f]) && !rd_done[f]
            |=> (fu_wr_row[f*NUM_REG +: NUM_REG] == '0)
                && $stable(fu_rd_row[f*NUM_REG +: NUM_REG])); // R6
    end
endmodule

bind fu_reg_dep_matrix frm_checker #(
    .NUM_FU (NUM_FU),
    .NUM_REG(NUM_REG),
    .NUM_SRC(NUM_SRC)
) u_frm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_fu   (issue_fu),
    .issue_dest (issue_dest),
    .issue_src  (issue_src),
    .rd_done    (rd_done),
    .wr_done    (wr_done),
    .issue_stall(issue_stall),
    .fu_rd_row  (fu_rd_row),
    .fu_wr_row  (fu_wr_row),
    .reg_rd_free(reg_rd_free),
    .reg_wr_free(reg_wr_free)
);

// File: tb/tb_fu_reg_dep_matrix.sv
module tb_fu_reg_dep_matrix;
    localparam int unsigned F  = 4;
    localparam int unsigned R  = 8;
    localparam int unsigned S  = 2;
    localparam int unsigned FR = F * R;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid = 1'b0;
    logic [F-1:0]    issue_fu = '0;
    logic [R-1:0]    issue_dest = '0;
    logic [S*R-1:0]  issue_src = '0;
    logic [F-1:0]    rd_done = '0;
    logic [F-1:0]    wr_done = '0;
    logic            issue_stall;
    logic [F-1:0]    fu_busy;
    logic [FR-1:0]   fu_rd_row;
    logic [FR-1:0]   fu_wr_row;
    logic [R-1:0]    reg_rd_free;
    logic [R-1:0]    reg_wr_free;

    logic [FR-1:0]   m_rd = '0;
    logic [FR-1:0]   m_wr = '0;
    int              n_checks = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    fu_reg_dep_matrix #(.NUM_FU(F), .NUM_REG(R), .NUM_SRC(S)) dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_fu(issue_fu),
        .issue_dest(issue_dest), .issue_src(issue_src), .rd_done(rd_done),
        .wr_done(wr_done), .issue_stall(issue_stall), .fu_busy(fu_busy),
        .fu_rd_row(fu_rd_row), .fu_wr_row(fu_wr_row),
        .reg_rd_free(reg_rd_free), .reg_wr_free(reg_wr_free)
    );

    function automatic logic [F-1:0] busy_of(input logic [FR-1:0] rd, input logic [FR-1:0] wr);
        logic [F-1:0] b;
        for (int f = 0; f < F; f++) b[f] = |{rd[f*R +: R], wr[f*R +: R]};
        return b;
    endfunction

    function automatic logic [R-1:0] free_of(input logic [FR-1:0] pl);
        logic [R-1:0] v = '1;
        for (int f = 0; f < F; f++) v = v & ~pl[f*R +: R];
        return v;
    endfunction

    function automatic logic [R-1:0] merge_src(input logic [S*R-1:0] src);
        logic [R-1:0] v = '0;
        for (int s = 0; s < S; s++) v = v | src[s*R +: R];
        return v;
    endfunction

    function automatic logic [R-1:0] rand_reg();
        if ($urandom_range(0, 3) == 0) return '0;
        return R'(1) << $urandom_range(0, R - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model; called away from the clock edge.
    task automatic check_all();
        check(fu_wr_row == m_wr, "R2", 64'(fu_wr_row), 64'(m_wr));
        check(fu_rd_row == m_rd, "R3", 64'(fu_rd_row), 64'(m_rd));
        check({reg_rd_free, reg_wr_free} == {free_of(m_rd), free_of(m_wr)}, "R4",
              64'({reg_rd_free, reg_wr_free}), 64'({free_of(m_rd), free_of(m_wr)}));
        check(fu_busy == busy_of(m_rd, m_wr), "R7", 64'(fu_busy), 64'(busy_of(m_rd, m_wr)));
    endtask

    // One cycle: drive at the falling edge, check stall, update model, check state.
    task automatic step(input logic v, input logic [F-1:0] fu, input logic [R-1:0] dst,
                        input logic [S*R-1:0] src, input logic [F-1:0] rdd, input logic [F-1:0] wrd,
                        output logic stall_seen);
        logic exp_stall;
        issue_valid = v; issue_fu = fu; issue_dest = dst; issue_src = src;
        rd_done = rdd; wr_done = wrd;
        #1;
        exp_stall = v && (!$onehot(fu) || (|(fu & busy_of(m_rd, m_wr))));
        check(issue_stall == exp_stall, "R7", 64'(issue_stall), 64'(exp_stall));
        stall_seen = issue_stall;
        @(posedge clk);
        for (int f = 0; f < F; f++) begin
            if (rdd[f]) m_rd[f*R +: R] = '0;
            if (wrd[f]) m_wr[f*R +: R] = '0;
            if (v && !exp_stall && fu[f]) begin
                m_rd[f*R +: R] = m_rd[f*R +: R] | merge_src(src);
                m_wr[f*R +: R] = m_wr[f*R +: R] | dst;
            end
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; issue_valid = 1'b0; rd_done = '0; wr_done = '0;
        @(posedge clk); @(posedge clk);
        m_rd = '0; m_wr = '0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check((fu_rd_row == '0) && (fu_wr_row == '0) && (fu_busy == '0), "R1",
              64'({fu_rd_row, fu_wr_row}), 64'(0));
        check((reg_rd_free == '1) && (reg_wr_free == '1) && !issue_stall, "R1",
              64'({issue_stall, reg_rd_free, reg_wr_free}), 64'({1'b0, {2*R{1'b1}}}));
    endtask

    initial begin
        #(64'd200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic st;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // R3: repeated source collapses to one bit; dest loads write bits (R2).
        step(1'b1, 4'b0001, 8'h04, {8'h10, 8'h10}, '0, '0, st);
        check(fu_rd_row[0 +: R] == 8'h10, "R3", 64'(fu_rd_row[0 +: R]), 64'h10);
        check(fu_wr_row[0 +: R] == 8'h04, "R2", 64'(fu_wr_row[0 +: R]), 64'h04);
        // R7: busy target stalls.
        step(1'b1, 4'b0001, 8'h01, '0, '0, '0, st);
        check(st == 1'b1, "R7", 64'(st), 64'd1);
        // R5: read strobe clears read bits only.
        step(1'b0, '0, '0, '0, 4'b0001, '0, st);
        check((fu_rd_row[0 +: R] == '0) && (fu_wr_row[0 +: R] == 8'h04), "R5",
              64'({fu_rd_row[0 +: R], fu_wr_row[0 +: R]}), 64'h0004);
        // R6: write strobe clears write bits only.
        step(1'b1, 4'b0010, 8'h80, {8'h02, 8'h01}, '0, '0, st);
        step(1'b0, '0, '0, '0, '0, 4'b0011, st);
        check((fu_wr_row[R +: R] == '0) && (fu_rd_row[R +: R] == 8'h03), "R6",
              64'({fu_rd_row[R +: R], fu_wr_row[R +: R]}), 64'h0300);
        // R8: zero and multi-bit targets are rejected.
        step(1'b1, 4'b0000, 8'h08, '0, '0, '0, st);
        check(st == 1'b1, "R8", 64'(st), 64'd1);
        step(1'b1, 4'b1100, 8'h08, '0, '0, '0, st);
        check((st == 1'b1) && (fu_wr_row[2*R +: 2*R] == '0), "R8",
              64'({st, fu_wr_row[2*R +: 2*R]}), 64'h10000);
        // R9: empty issue accepted and leaves row idle.
        step(1'b1, 4'b0100, '0, '0, '0, '0, st);
        check((st == 1'b0) && (fu_busy[2] == 1'b0), "R9", 64'({st, fu_busy[2]}), 64'd0);
        // R10: strobes coincident with an issue to the same idle row keep new bits.
        step(1'b1, 4'b1000, 8'h20, {8'h40, 8'h01}, 4'b1000, 4'b1000, st);
        check((fu_rd_row[3*R +: R] == 8'h41) && (fu_wr_row[3*R +: R] == 8'h20), "R10",
              64'({fu_rd_row[3*R +: R], fu_wr_row[3*R +: R]}), 64'h4120);

        // Random traffic mixing issues, bad targets and retire strobes.
        for (int i = 0; i < 3000; i++) begin
            logic [F-1:0]   fu;
            logic [S*R-1:0] src;
            int             pick;
            pick = $urandom_range(0, 9);
            if (pick == 0)      fu = '0;
            else if (pick == 1) fu = F'($urandom_range(0, (1 << F) - 1));
            else                fu = F'(1) << $urandom_range(0, F - 1);
            for (int s = 0; s < S; s++) src[s*R +: R] = rand_reg();
            step($urandom_range(0, 3) != 0, fu, rand_reg(), src,
                 F'($urandom_range(0, (1 << F) - 1)) & F'($urandom_range(0, (1 << F) - 1)),
                 F'($urandom_range(0, (1 << F) - 1)) & F'($urandom_range(0, (1 << F) - 1)), st);
        end

        // R1: reset in the middle of traffic empties the matrix.
        step(1'b1, 4'b0001, 8'h02, {8'h00, 8'h04}, 4'b0001, 4'b0001, st);
        @(negedge clk);
        do_reset();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule